// File: doc/BRIEF.md
# MAC Operand Address Generator

This block is the decode-stage address unit for multiply-accumulate instructions. It holds a small set of address registers: index pointers, two kinds of offset registers (X offsets and R offsets) and a bank of general-purpose pointers. For each decoded instruction it reads the selected index pointer and general pointer. It presents them as the first and second operand addresses in the execute stage. It then post-modifies both pointers.

The index pointer may advance by a selected X offset. The new value is written at the end of decode. The general pointer may step up or down by a fixed amount, or advance by a selected R offset. That new value is written at the end of execute. Two instruction variants also produce a memory write address in the writeback stage. The move-and-accumulate variant writes to the old index pointer minus the X offset. The move variant writes to the old index pointer. A configuration write port loads any register. Such a write is not forwarded to a decode in the same cycle, and it takes priority over a post-modify of the same register.

Top module: `mac_agu`

## Requirements
- R1: After synchronous reset, every index pointer, X offset, R offset and general pointer is zero, and `ex_valid` and `wb_valid` are low.
- R2: A decode with `dec_valid` high gives `ex_valid` high on the next cycle. In that cycle `ex_op` equals the decoded `dec_op`, and `ex_op1_addr` equals the index pointer chosen by `dec_idx_sel` as it stood during the decode.
- R3: With `dec_idx_mode` = 1, the chosen index pointer becomes its old value plus the X offset chosen by `dec_qx_sel`, modulo 2^16. A decode in the very next cycle sees the new value. With `dec_idx_mode` = 0 the pointer keeps its value.
- R4: `ex_op2_addr` equals the general pointer chosen by `dec_gpr_sel` during the decode. `dec_gpr_mode` then updates that pointer, modulo 2^16: 0 keeps it, 1 adds 2, 2 subtracts 2, and 3 adds the R offset chosen by `dec_qr_sel`.
- R5: A general pointer update is written at the end of the execute stage. A decode one cycle later still reads the old value, and a decode two cycles later reads the new one.
- R6: For `dec_op` = 1 (move-and-accumulate), `wb_valid` is high two cycles after the decode. `wb_addr` is then the old index pointer minus the chosen X offset, modulo 2^16.
- R7: For `dec_op` = 2 (move), `wb_valid` is high two cycles after the decode, and `wb_addr` is then the old index pointer. For `dec_op` = 0 (plain accumulate) and for `dec_op` = 3, `wb_valid` stays low.
- R8: A configuration write (`cfg_we`) is not forwarded to a decode in the same cycle. A decode in the next cycle sees the written value. `cfg_kind` selects the register class: 0 index pointer, 1 X offset, 2 R offset, 3 general pointer. For the first three classes only the low bit of `cfg_sel` is used.
- R9: If a configuration write and a post-modify hit the same register in the same cycle, the configuration value is kept.
- R10: While `dec_valid` is low, `ex_valid` goes low on the next cycle and no pointer is modified, whatever the other decode fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | Register class of the write |
| cfg_sel | input | 4 | Register number within the class |
| cfg_data | input | 16 | Value to write |
| dec_valid | input | 1 | An instruction is in decode |
| dec_op | input | 2 | Instruction variant |
| dec_idx_sel | input | 1 | Index pointer select |
| dec_qx_sel | input | 1 | X offset select |
| dec_idx_mode | input | 1 | 1: post-add the X offset to the index pointer |
| dec_gpr_sel | input | 4 | General pointer select |
| dec_gpr_mode | input | 2 | General pointer post-modify mode |
| dec_qr_sel | input | 1 | R offset select |
| ex_valid | output | 1 | Execute-stage addresses are valid |
| ex_op | output | 2 | Variant of the instruction in execute |
| ex_op1_addr | output | 16 | First operand read address |
| ex_op2_addr | output | 16 | Second operand address |
| wb_valid | output | 1 | Writeback-stage write request |
| wb_addr | output | 16 | Writeback write address |

## Verification
The assertions check on every cycle that execute-stage validity follows decode validity, that move and move-and-accumulate instructions raise a writeback request one stage later while the other variants do not, that a move writes back to its own first operand address, and that register-bank writes land with the configuration write taking priority. Only the bench's scenarios can show the arithmetic of the post-modify modes and wrap-around. The same holds for the different visibility delays of index and general pointer updates, and for the absence of forwarding from the configuration port. The bench covers these with directed sequences and a long random run checked against its own model.

// File: rtl/mac_agu_pkg.sv
package mac_agu_pkg;

  typedef enum logic [1:0] {
    OP_MAC  = 2'd0,
    OP_MACM = 2'd1,
    OP_MOV  = 2'd2,
    OP_RSV  = 2'd3
  } mac_op_e;

  typedef enum logic [1:0] {
    KIND_IDX = 2'd0,
    KIND_QX  = 2'd1,
    KIND_QR  = 2'd2,
    KIND_GPR = 2'd3
  } reg_kind_e;

  typedef enum logic [1:0] {
    GM_KEEP = 2'd0,
    GM_INC  = 2'd1,
    GM_DEC  = 2'd2,
    GM_ADDQ = 2'd3
  } gpr_mode_e;

endpackage

// File: rtl/mac_agu_bank.sv
module mac_agu_bank #(
  parameter int AW    = 16,
  parameter int DEPTH = 2,
  parameter int SW    = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sw_we,
  input  logic [SW-1:0] sw_sel,
  input  logic [AW-1:0] sw_data,
  input  logic          pm_we,
  input  logic [SW-1:0] pm_sel,
  input  logic [AW-1:0] pm_data,
  input  logic [SW-1:0] rd_sel,
  output logic [AW-1:0] rd_data
);

  logic [AW-1:0] mem [DEPTH];

  // Post-modify first, configuration write last so that it wins (R9).
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (pm_we) mem[pm_sel] <= pm_data;
      if (sw_we) mem[sw_sel] <= sw_data;
    end
  end

  assign rd_data = mem[rd_sel];

  a_r9_cfg_write_wins: assert property (@(posedge clk) disable iff (rst)
    sw_we |=> (mem[$past(sw_sel)] == $past(sw_data)));

  a_r3_postmod_lands: assert property (@(posedge clk) disable iff (rst)
    (pm_we && !(sw_we && (sw_sel == pm_sel))) |=> (mem[$past(pm_sel)] == $past(pm_data)));

endmodule

// File: rtl/mac_agu_idx_path.sv
module mac_agu_idx_path
  import mac_agu_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [AW-1:0] idx_old,
  input  logic [AW-1:0] qx,
  input  logic          add_mode,
  input  mac_op_e       op,
  output logic [AW-1:0] idx_new,
  output logic          wb_en,
  output logic [AW-1:0] wb_addr
);

  always_comb begin
    idx_new = add_mode ? (idx_old + qx) : idx_old;
    unique case (op)
      OP_MACM: begin
        wb_en   = 1'b1;
        wb_addr = idx_old - qx;
      end
      OP_MOV: begin
        wb_en   = 1'b1;
        wb_addr = idx_old;
      end
      default: begin
        wb_en   = 1'b0;
        wb_addr = idx_old;
      end
    endcase
  end

endmodule

// File: rtl/mac_agu_gpr_path.sv
module mac_agu_gpr_path
  import mac_agu_pkg::*;
#(
  parameter int AW   = 16,
  parameter int STEP = 2
) (
  input  logic [AW-1:0] gpr_old,
  input  logic [AW-1:0] qr,
  input  gpr_mode_e     mode,
  output logic [AW-1:0] gpr_new,
  output logic          upd
);

  localparam logic [AW-1:0] STEP_V = AW'(STEP);

  always_comb begin
    upd = 1'b1;
    unique case (mode)
      GM_INC:  gpr_new = gpr_old + STEP_V;
      GM_DEC:  gpr_new = gpr_old - STEP_V;
      GM_ADDQ: gpr_new = gpr_old + qr;
      default: begin
        gpr_new = gpr_old;
        upd     = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/mac_agu.sv
module mac_agu
  import mac_agu_pkg::*;
#(
  parameter int AW    = 16,
  parameter int N_IDX = 2,
  parameter int N_QX  = 2,
  parameter int N_QR  = 2,
  parameter int N_GPR = 16,
  parameter int STEP  = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_kind,
  input  logic [3:0]  cfg_sel,
  input  logic [15:0] cfg_data,
  input  logic        dec_valid,
  input  logic [1:0]  dec_op,
  input  logic        dec_idx_sel,
  input  logic        dec_qx_sel,
  input  logic        dec_idx_mode,
  input  logic [3:0]  dec_gpr_sel,
  input  logic [1:0]  dec_gpr_mode,
  input  logic        dec_qr_sel,
  output logic        ex_valid,
  output logic [1:0]  ex_op,
  output logic [15:0] ex_op1_addr,
  output logic [15:0] ex_op2_addr,
  output logic        wb_valid,
  output logic [15:0] wb_addr
);

  localparam int IW = (N_IDX > 1) ? $clog2(N_IDX) : 1;
  localparam int XW = (N_QX  > 1) ? $clog2(N_QX)  : 1;
  localparam int RW = (N_QR  > 1) ? $clog2(N_QR)  : 1;
  localparam int GW = (N_GPR > 1) ? $clog2(N_GPR) : 1;

  // Decode-stage reads
  logic [AW-1:0] idx_old, qx_val, qr_val, gpr_old;
  logic [AW-1:0] idx_new, gpr_new, wb_addr_d;
  logic          wb_en_d, gpr_upd;

  // Execute-stage state
  logic          ex_wb_en;
  logic [AW-1:0] ex_wb_addr;
  logic          ex_gpr_we;
  logic [GW-1:0] ex_gpr_sel;
  logic [AW-1:0] ex_gpr_val;

  logic we_idx, we_qx, we_qr, we_gpr;
  assign we_idx = cfg_we && (cfg_kind == KIND_IDX);
  assign we_qx  = cfg_we && (cfg_kind == KIND_QX);
  assign we_qr  = cfg_we && (cfg_kind == KIND_QR);
  assign we_gpr = cfg_we && (cfg_kind == KIND_GPR);

  // Index pointers: post-modified at the end of decode (R3)
  mac_agu_bank #(.AW(AW), .DEPTH(N_IDX), .SW(IW)) u_idx (
    .clk(clk), .rst(rst),
    .sw_we(we_idx), .sw_sel(cfg_sel[IW-1:0]), .sw_data(cfg_data[AW-1:0]),
    .pm_we(dec_valid && dec_idx_mode), .pm_sel(IW'(dec_idx_sel)), .pm_data(idx_new),
    .rd_sel(IW'(dec_idx_sel)), .rd_data(idx_old)
  );

  mac_agu_bank #(.AW(AW), .DEPTH(N_QX), .SW(XW)) u_qx (
    .clk(clk), .rst(rst),
    .sw_we(we_qx), .sw_sel(cfg_sel[XW-1:0]), .sw_data(cfg_data[AW-1:0]),
    .pm_we(1'b0), .pm_sel('0), .pm_data('0),
    .rd_sel(XW'(dec_qx_sel)), .rd_data(qx_val)
  );

  mac_agu_bank #(.AW(AW), .DEPTH(N_QR), .SW(RW)) u_qr (
    .clk(clk), .rst(rst),
    .sw_we(we_qr), .sw_sel(cfg_sel[RW-1:0]), .sw_data(cfg_data[AW-1:0]),
    .pm_we(1'b0), .pm_sel('0), .pm_data('0),
    .rd_sel(RW'(dec_qr_sel)), .rd_data(qr_val)
  );

  // General pointers: written back at the end of execute (R5)
  mac_agu_bank #(.AW(AW), .DEPTH(N_GPR), .SW(GW)) u_gpr (
    .clk(clk), .rst(rst),
    .sw_we(we_gpr), .sw_sel(cfg_sel[GW-1:0]), .sw_data(cfg_data[AW-1:0]),
    .pm_we(ex_gpr_we), .pm_sel(ex_gpr_sel), .pm_data(ex_gpr_val),
    .rd_sel(dec_gpr_sel[GW-1:0]), .rd_data(gpr_old)
  );

  mac_agu_idx_path #(.AW(AW)) u_idx_path (
    .idx_old(idx_old), .qx(qx_val), .add_mode(dec_idx_mode),
    .op(mac_op_e'(dec_op)),
    .idx_new(idx_new), .wb_en(wb_en_d), .wb_addr(wb_addr_d)
  );

  mac_agu_gpr_path #(.AW(AW), .STEP(STEP)) u_gpr_path (
    .gpr_old(gpr_old), .qr(qr_val), .mode(gpr_mode_e'(dec_gpr_mode)),
    .gpr_new(gpr_new), .upd(gpr_upd)
  );

  // Decode -> execute register
  always_ff @(posedge clk) begin
    if (rst) begin
      ex_valid    <= 1'b0;
      ex_op       <= OP_MAC;
      ex_op1_addr <= '0;
      ex_op2_addr <= '0;
      ex_wb_en    <= 1'b0;
      ex_wb_addr  <= '0;
      ex_gpr_we   <= 1'b0;
      ex_gpr_sel  <= '0;
      ex_gpr_val  <= '0;
    end else begin
      ex_valid    <= dec_valid;
      ex_op       <= dec_op;
      ex_op1_addr <= idx_old;
      ex_op2_addr <= gpr_old;
      ex_wb_en    <= dec_valid && wb_en_d;
      ex_wb_addr  <= wb_addr_d;
      ex_gpr_we   <= dec_valid && gpr_upd;
      ex_gpr_sel  <= dec_gpr_sel[GW-1:0];
      ex_gpr_val  <= gpr_new;
    end
  end

  // Execute -> writeback register
  always_ff @(posedge clk) begin
    if (rst) begin
      wb_valid <= 1'b0;
      wb_addr  <= '0;
    end else begin
      wb_valid <= ex_wb_en;
      wb_addr  <= ex_wb_addr;
    end
  end

  a_r10_ex_follows_dec: assert property (@(posedge clk) disable iff (rst)
    dec_valid |=> ex_valid);

  a_r10_idle_no_ex: assert property (@(posedge clk) disable iff (rst)
    !dec_valid |=> !ex_valid);

  a_r6_macm_requests_wb: assert property (@(posedge clk) disable iff (rst)
    (ex_valid && (ex_op == OP_MACM)) |=> wb_valid);

  a_r7_mov_targets_op1: assert property (@(posedge clk) disable iff (rst)
    (ex_valid && (ex_op == OP_MOV)) |=> (wb_valid && (wb_addr == $past(ex_op1_addr))));

  a_r7_mac_no_wb: assert property (@(posedge clk) disable iff (rst)
    (!ex_valid || (ex_op == OP_MAC) || (ex_op == OP_RSV)) |=> !wb_valid);

  a_r6_wb_has_cause: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> $past(ex_valid));

endmodule

// File: tb/mac_agu_tb.sv
module mac_agu_tb_top;
  import mac_agu_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        c_we = 1'b0;
  logic [1:0]  c_kind = '0;
  logic [3:0]  c_sel = '0;
  logic [15:0] c_data = '0;
  logic        d_v = 1'b0;
  logic [1:0]  d_op = '0;
  logic        d_is = 1'b0, d_xs = 1'b0, d_im = 1'b0, d_rs = 1'b0;
  logic [3:0]  d_gs = '0;
  logic [1:0]  d_gm = '0;

  logic        ex_valid, wb_valid;
  logic [1:0]  ex_op;
  logic [15:0] ex_op1_addr, ex_op2_addr, wb_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_agu dut_i (
    .clk(clk), .rst(rst),
    .cfg_we(c_we), .cfg_kind(c_kind), .cfg_sel(c_sel), .cfg_data(c_data),
    .dec_valid(d_v), .dec_op(d_op), .dec_idx_sel(d_is), .dec_qx_sel(d_xs),
    .dec_idx_mode(d_im), .dec_gpr_sel(d_gs), .dec_gpr_mode(d_gm), .dec_qr_sel(d_rs),
    .ex_valid(ex_valid), .ex_op(ex_op), .ex_op1_addr(ex_op1_addr),
    .ex_op2_addr(ex_op2_addr), .wb_valid(wb_valid), .wb_addr(wb_addr)
  );

  int n_tests = 0;
  int n_fail  = 0;
  string scen = "R1";

  // Behavioural reference state
  logic [15:0] m_idx [2];
  logic [15:0] m_qx  [2];
  logic [15:0] m_qr  [2];
  logic [15:0] m_gpr [16];
  bit          pend_we;
  int          pend_sel;
  logic [15:0] pend_val;
  bit          e_exv, e_exwb, e_wbv;
  logic [1:0]  e_op;
  logic [15:0] e_op1, e_op2, e_exwb_a, e_wba;

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 2; i++) begin m_idx[i] = 0; m_qx[i] = 0; m_qr[i] = 0; end
    for (int i = 0; i < 16; i++) m_gpr[i] = 0;
    pend_we = 0; pend_sel = 0; pend_val = 0;
    e_exv = 0; e_exwb = 0; e_wbv = 0; e_op = 0;
    e_op1 = 0; e_op2 = 0; e_exwb_a = 0; e_wba = 0;
  endtask

  // One clock: predict, advance, compare.
  task automatic cycle();
    logic [15:0] io, q, g, r, gn;
    bit n_pend;
    io = m_idx[d_is]; q = m_qx[d_xs]; g = m_gpr[d_gs]; r = m_qr[d_rs];
    e_wbv = e_exwb; e_wba = e_exwb_a;
    e_exv = d_v; e_op = d_op; e_op1 = io; e_op2 = g;
    e_exwb = d_v && (d_op == 2'd1 || d_op == 2'd2);
    e_exwb_a = (d_op == 2'd1) ? 16'(io - q) : io;
    n_pend = d_v && (d_gm != 2'd0);
    case (d_gm)
      2'd1:    gn = g + 16'd2;
      2'd2:    gn = g - 16'd2;
      2'd3:    gn = g + r;
      default: gn = g;
    endcase
    if (pend_we) m_gpr[pend_sel] = pend_val;
    if (d_v && d_im) m_idx[d_is] = io + q;
    if (c_we) begin
      case (c_kind)
        2'd0: m_idx[c_sel[0]] = c_data;
        2'd1: m_qx[c_sel[0]]  = c_data;
        2'd2: m_qr[c_sel[0]]  = c_data;
        default: m_gpr[c_sel] = c_data;
      endcase
    end
    pend_we = n_pend; pend_sel = int'(d_gs); pend_val = gn;
    @(posedge clk);
    #1;
    chk({scen, " R10 ex_valid"}, 16'(ex_valid), 16'(e_exv));
    if (e_exv) begin
      chk({scen, " R2 ex_op"}, 16'(ex_op), 16'(e_op));
      chk({scen, " R2 op1"}, ex_op1_addr, e_op1);
      chk({scen, " R4 op2"}, ex_op2_addr, e_op2);
    end
    chk({scen, " R6 wb_valid"}, 16'(wb_valid), 16'(e_wbv));
    if (e_wbv) chk({scen, " R7 wb_addr"}, wb_addr, e_wba);
  endtask

  task automatic idle();
    d_v = 0; c_we = 0;
  endtask

  task automatic dec(input logic [1:0] op, input logic is, input logic xs, input logic im,
                     input logic [3:0] gs, input logic [1:0] gm, input logic rs);
    c_we = 0; d_v = 1; d_op = op; d_is = is; d_xs = xs; d_im = im;
    d_gs = gs; d_gm = gm; d_rs = rs;
  endtask

  task automatic cfgw(input logic [1:0] k, input logic [3:0] s, input logic [15:0] v);
    d_v = 0; c_we = 1; c_kind = k; c_sel = s; c_data = v;
    cycle();
    c_we = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst = 0;

    // R1: reset state
    scen = "R1";
    chk("R1 ex_valid after reset", 16'(ex_valid), 16'd0);
    chk("R1 wb_valid after reset", 16'(wb_valid), 16'd0);
    dec(2'd1, 0, 0, 0, 4'd5, 2'd0, 0); cycle();
    chk("R1 idx0 zero", ex_op1_addr, 16'h0000);
    chk("R1 gpr5 zero", ex_op2_addr, 16'h0000);
    idle(); cycle();
    chk("R1 wb from zero regs", wb_addr, 16'h0000);

    // R3: index post-add with wrap
    scen = "R3";
    cfgw(2'd0, 4'd0, 16'hFFF0);
    cfgw(2'd1, 4'd1, 16'h0020);
    dec(2'd0, 0, 1, 1, 4'd0, 2'd0, 0); cycle();
    chk("R3 old idx", ex_op1_addr, 16'hFFF0);
    dec(2'd0, 0, 1, 0, 4'd0, 2'd0, 0); cycle();
    chk("R3 wrapped idx next cycle", ex_op1_addr, 16'h0010);
    cycle();
    chk("R3 mode0 holds", ex_op1_addr, 16'h0010);

    // R8: no forwarding of a same-cycle config write
    scen = "R8";
    dec(2'd0, 1, 0, 0, 4'd0, 2'd0, 0);
    c_we = 1; c_kind = 2'd0; c_sel = 4'd1; c_data = 16'h2222;
    cycle(); c_we = 0;
    chk("R8 same-cycle write not seen", ex_op1_addr, 16'h0000);
    cycle();
    chk("R8 write seen next cycle", ex_op1_addr, 16'h2222);

    // R9: config write beats post-modify
    scen = "R9";
    dec(2'd0, 1, 1, 1, 4'd0, 2'd0, 0);
    c_we = 1; c_kind = 2'd0; c_sel = 4'd1; c_data = 16'h5555;
    cycle(); c_we = 0;
    dec(2'd0, 1, 1, 0, 4'd0, 2'd0, 0); cycle();
    chk("R9 config value kept", ex_op1_addr, 16'h5555);

    // R4 / R5: general pointer modes and execute-stage writeback
    scen = "R5";
    cfgw(2'd3, 4'd3, 16'h0100);
    dec(2'd0, 0, 0, 0, 4'd3, 2'd1, 0); cycle();
    chk("R5 first read", ex_op2_addr, 16'h0100);
    dec(2'd0, 0, 0, 0, 4'd3, 2'd1, 0); cycle();
    chk("R5 next-cycle decode sees old", ex_op2_addr, 16'h0100);
    dec(2'd0, 0, 0, 0, 4'd3, 2'd0, 0); cycle();
    chk("R5 two cycles later sees new", ex_op2_addr, 16'h0102);
    cycle();
    chk("R5 overlapping updates give +2", ex_op2_addr, 16'h0102);
    scen = "R4";
    dec(2'd0, 0, 0, 0, 4'd4, 2'd2, 0); cycle();
    idle(); cycle();
    dec(2'd0, 0, 0, 0, 4'd4, 2'd0, 0); cycle();
    chk("R4 decrement wraps", ex_op2_addr, 16'hFFFE);
    cfgw(2'd2, 4'd1, 16'h0300);
    cfgw(2'd3, 4'd6, 16'hFF00);
    dec(2'd0, 0, 0, 0, 4'd6, 2'd3, 1); cycle();
    idle(); cycle();
    dec(2'd0, 0, 0, 0, 4'd6, 2'd0, 0); cycle();
    chk("R4 add R offset wraps", ex_op2_addr, 16'h0200);

    // R6 / R7: writeback addresses
    scen = "R6";
    cfgw(2'd0, 4'd0, 16'h0040);
    cfgw(2'd1, 4'd0, 16'h0008);
    dec(2'd1, 0, 0, 0, 4'd0, 2'd0, 0); cycle();
    idle(); cycle();
    chk("R6 wb_valid", 16'(wb_valid), 16'd1);
    chk("R6 wb idx minus X offset", wb_addr, 16'h0038);
    scen = "R7";
    dec(2'd2, 0, 0, 0, 4'd0, 2'd0, 0); cycle();
    idle(); cycle();
    chk("R7 move wb address", wb_addr, 16'h0040);
    dec(2'd0, 0, 0, 0, 4'd0, 2'd0, 0); cycle();
    idle(); cycle();
    chk("R7 plain op no wb", 16'(wb_valid), 16'd0);
    dec(2'd3, 0, 0, 0, 4'd0, 2'd0, 0); cycle();
    idle(); cycle();
    chk("R7 op3 no wb", 16'(wb_valid), 16'd0);

    // R10: invalid decode changes nothing
    scen = "R10";
    dec(2'd1, 0, 0, 1, 4'd3, 2'd1, 0); d_v = 0; cycle();
    chk("R10 no ex_valid", 16'(ex_valid), 16'd0);
    dec(2'd0, 0, 0, 0, 4'd3, 2'd0, 0); cycle();
    chk("R10 idx unchanged", ex_op1_addr, 16'h0040);
    chk("R10 gpr unchanged", ex_op2_addr, 16'h0102);

    // Random traffic against the reference
    scen = "RND";
    for (int n = 0; n < 3000; n++) begin
      d_v = ($urandom_range(0, 3) != 0);
      d_op = 2'($urandom); d_is = 1'($urandom); d_xs = 1'($urandom);
      d_im = 1'($urandom); d_gs = 4'($urandom); d_gm = 2'($urandom);
      d_rs = 1'($urandom);
      c_we = ($urandom_range(0, 4) == 0);
      c_kind = 2'($urandom); c_sel = 4'($urandom); c_data = 16'($urandom);
      cycle();
    end
    idle(); cycle(); cycle();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule